// File: doc/BRIEF.md
# Addressable LED Pixel Receiver

This block is the control logic of one chainable RGB pixel. A single data wire arrives from the previous pixel. The block oversamples that wire with its own clock and measures each high pulse in clock cycles. A pulse of at least `HI_THRESH` cycles is a one and a shorter pulse is a zero. There is no band of rejected widths between the two. A decoded bit stays pending until the next rising edge of the wire and is committed there. A low stretch of `GAP_CYC` cycles marks the end of a frame. Low stretches shorter than that, even very long ones, are just slow bits.

After a frame boundary, the first 24 committed bits belong to this pixel. They arrive green first, then red, then blue, each byte most significant bit first. At the next frame boundary they are copied into the colour outputs, which drive the LED current sinks. Every committed bit after the 24th is sent on to the next pixel as a fresh pulse with a fixed width, so the timing errors of the incoming wire do not build up along the chain. The output trails the input by one bit period. The pending last bit of a frame goes out when the frame boundary is detected.

Top module: `led_pixel_rx`

## Requirements
- R1: While `rst` is high at a clock edge, the three colour outputs become zero and `dout` becomes low.
- R2: A high pulse that lasts at least `HI_THRESH` clock cycles decodes as 1. A shorter pulse decodes as 0. With the defaults, 75 cycles gives 1 and 74 cycles gives 0.
- R3: The first 24 bits after a frame boundary fill the colour outputs in the order green, red, blue, with bit 7 of each byte received first.
- R4: The colour outputs change only in the cycle after a frame boundary is detected. They keep their values while a new frame is being received.
- R5: The input held low for `GAP_CYC` cycles is a frame boundary. A low of `GAP_CYC`-10 cycles, or of 2500 cycles (20 us at 125 MHz) inside a frame, is not a boundary.
- R6: At a frame boundary, if fewer than 24 bits were received since the previous boundary, the colour outputs keep their old values.
- R7: Each bit after the 24th is forwarded on `dout` as a high pulse of exactly `ONE_HI` cycles for a 1 or `ZERO_HI` cycles for a 0. The pulse starts at the rising edge that commits the bit. The last bit of a frame is forwarded at the frame boundary.
- R8: `dout` stays low while the pixel is still collecting its own 24 bits and while the wire is idle.
- R9: A frame boundary restarts the bit count. The next frame's first 24 bits again go to this pixel's colour registers and are not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data from the upstream pixel (asynchronous) |
| grn_o | output | CHAN_W | Latched green intensity |
| red_o | output | CHAN_W | Latched red intensity |
| blu_o | output | CHAN_W | Latched blue intensity |
| dout | output | 1 | Regenerated serial data to the downstream pixel |

## Verification
A change on `din` reaches the internal level two edges later, through the synchronizer. A forwarded pulse therefore appears on `dout` four edges after the rising edge of `din` that commits its bit. The colour outputs change about `GAP_CYC`+4 cycles after the last falling edge of a frame. The bench makes no check inside those windows. It waits `GAP_CYC`+`ONE_HI`+20 cycles before it reads the colours. It judges `dout` by the width of each high run, sampled on falling clock edges, and not by the position of the pulse. Checks that colours hold and that `dout` stays silent are made at the point where all bits of interest have been driven, before any frame boundary can occur.

// File: rtl/pixrx_pkg.sv
package pixrx_pkg;
  localparam int unsigned PIX_CHANNELS = 3;

  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pixrx_sync_edge.sv
module pixrx_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   lvl_d;

  // Stage 0 samples the asynchronous wire; the rest only re-register it.
  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b0;
    else     chain_q[0] <= din;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= 1'b0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= chain_q[SYNC_STAGES-1];
  end

  assign lvl  = chain_q[SYNC_STAGES-1];
  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;
endmodule

// File: rtl/pixrx_pulse_timer.sv
module pixrx_pulse_timer
  import pixrx_pkg::*;
#(
  parameter int HI_THRESH = 75,
  parameter int GAP_CYC   = 6250
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic rise,
  input  logic fall,
  output logic bit_vld,
  output logic bit_val,
  output logic gap_evt
);
  localparam int HW = cnt_bits(HI_THRESH);
  localparam int LW = cnt_bits(GAP_CYC);
  localparam logic [HW-1:0] HI_SAT  = HW'(HI_THRESH);
  localparam logic [LW-1:0] LO_SAT  = LW'(GAP_CYC);
  localparam logic [LW-1:0] LO_FIRE = LW'(GAP_CYC - 1);

  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;

  // The high-time counter saturates at the threshold: only the comparison matters.
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
    end else if (rise) begin
      hi_cnt <= HW'(1);
    end else if (lvl && hi_cnt != HI_SAT) begin
      hi_cnt <= hi_cnt + HW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_vld <= 1'b0;
      bit_val <= 1'b0;
    end else begin
      bit_vld <= fall;
      if (fall) bit_val <= (hi_cnt >= HI_SAT);
    end
  end

  // Low-time counter: one boundary event per idle stretch, then it parks.
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt  <= '0;
      gap_evt <= 1'b0;
    end else begin
      gap_evt <= !lvl && (lo_cnt == LO_FIRE);
      if (lvl)                  lo_cnt <= '0;
      else if (lo_cnt != LO_SAT) lo_cnt <= lo_cnt + LW'(1);
    end
  end
endmodule

// File: rtl/pixrx_frame.sv
module pixrx_frame
  import pixrx_pkg::*;
#(
  parameter int CHAN_W   = 8,
  parameter int CHANNELS = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bit_vld,
  input  logic                         bit_val,
  input  logic                         rise,
  input  logic                         gap_evt,
  output logic [CHANNELS*CHAN_W-1:0]   hold_o,
  output logic                         fwd_go,
  output logic                         fwd_bit,
  output logic                         full_o
);
  localparam int FRAME = CHANNELS * CHAN_W;
  localparam int NW    = cnt_bits(FRAME);
  localparam logic [NW-1:0] FRAME_N = NW'(FRAME);

  logic [FRAME-1:0] shreg, shreg_nx;
  logic [NW-1:0]    nbits, nbits_nx;
  logic             pend_v, pend_b;
  logic             commit, keep, fwd;

  always_comb begin
    commit   = pend_v & (rise | gap_evt);
    keep     = commit && (nbits != FRAME_N);
    fwd      = commit && (nbits == FRAME_N);
    shreg_nx = keep ? {shreg[FRAME-2:0], pend_b} : shreg;
    nbits_nx = keep ? nbits + NW'(1) : nbits;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      nbits   <= '0;
      pend_v  <= 1'b0;
      pend_b  <= 1'b0;
      hold_o  <= '0;
      fwd_go  <= 1'b0;
      fwd_bit <= 1'b0;
    end else begin
      shreg <= shreg_nx;
      if (gap_evt) nbits <= '0;
      else         nbits <= nbits_nx;
      // Copy only a complete frame; partial frames leave the LED unchanged.
      if (gap_evt && nbits_nx == FRAME_N) hold_o <= shreg_nx;
      if (bit_vld) begin
        pend_v <= 1'b1;
        pend_b <= bit_val;
      end else if (commit) begin
        pend_v <= 1'b0;
      end
      fwd_go  <= fwd;
      fwd_bit <= pend_b;
    end
  end

  assign full_o = (nbits == FRAME_N);
endmodule

// File: rtl/pixrx_regen.sv
module pixrx_regen
  import pixrx_pkg::*;
#(
  parameter int ONE_HI  = 100,
  parameter int ZERO_HI = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic bitv,
  output logic dout
);
  localparam int PW = cnt_bits(ONE_HI);
  localparam logic [PW-1:0] ONE_LAST  = PW'(ONE_HI - 1);
  localparam logic [PW-1:0] ZERO_LAST = PW'(ZERO_HI - 1);

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 1'b0;
      pcnt <= '0;
    end else if (go) begin
      dout <= 1'b1;
      pcnt <= bitv ? ONE_LAST : ZERO_LAST;
    end else if (dout) begin
      if (pcnt == '0) dout <= 1'b0;
      else            pcnt <= pcnt - PW'(1);
    end
  end
endmodule

// File: rtl/led_pixel_rx.sv
module led_pixel_rx
  import pixrx_pkg::*;
#(
  parameter int CHAN_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HI_THRESH   = 75,
  parameter int GAP_CYC     = 6250,
  parameter int ONE_HI      = 100,
  parameter int ZERO_HI     = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  output logic [CHAN_W-1:0] grn_o,
  output logic [CHAN_W-1:0] red_o,
  output logic [CHAN_W-1:0] blu_o,
  output logic              dout
);
  localparam int CHANNELS = PIX_CHANNELS;
  localparam int FRAME    = CHANNELS * CHAN_W;

  logic             lvl, rise, fall;
  logic             bit_vld, bit_val, gap_evt;
  logic             fwd_go, fwd_bit, frame_full;
  logic [FRAME-1:0] hold;
  logic [CHAN_W-1:0] chan [CHANNELS];

  pixrx_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(din), .lvl(lvl), .rise(rise), .fall(fall)
  );

  pixrx_pulse_timer #(.HI_THRESH(HI_THRESH), .GAP_CYC(GAP_CYC)) u_timer (
    .clk(clk), .rst(rst), .lvl(lvl), .rise(rise), .fall(fall),
    .bit_vld(bit_vld), .bit_val(bit_val), .gap_evt(gap_evt)
  );

  pixrx_frame #(.CHAN_W(CHAN_W), .CHANNELS(CHANNELS)) u_frame (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val), .rise(rise),
    .gap_evt(gap_evt), .hold_o(hold), .fwd_go(fwd_go), .fwd_bit(fwd_bit),
    .full_o(frame_full)
  );

  pixrx_regen #(.ONE_HI(ONE_HI), .ZERO_HI(ZERO_HI)) u_regen (
    .clk(clk), .rst(rst), .go(fwd_go), .bitv(fwd_bit), .dout(dout)
  );

  // Channel 0 is the first byte on the wire and occupies the top of the frame.
  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    assign chan[c] = hold[FRAME-1-c*CHAN_W -: CHAN_W];
  end

  assign grn_o = chan[0];
  assign red_o = chan[1];
  assign blu_o = chan[2];
endmodule

// File: rtl/pixrx_chk.sv
module pixrx_chk #(
  parameter int CHAN_W  = 8,
  parameter int ONE_HI  = 100,
  parameter int ZERO_HI = 50
) (
  input logic              clk,
  input logic              rst,
  input logic              lvl,
  input logic              gap_evt,
  input logic              frame_full,
  input logic              dout,
  input logic [CHAN_W-1:0] grn_o,
  input logic [CHAN_W-1:0] red_o,
  input logic [CHAN_W-1:0] blu_o
);
  logic        rst_d;
  logic [31:0] run;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)       run <= '0;
    else if (dout) run <= run + 32'd1;
    else           run <= '0;
  end

  // R1: outputs cleared after a reset edge
  always @(negedge clk) begin
    if (rst_d === 1'b1) begin
      a_r1_reset_clear: assert (grn_o == '0 && red_o == '0 && blu_o == '0 && dout == 1'b0)
        else $error("R1 reset state not clear");
    end
  end

  // R4: colours move only right after a boundary event
  a_r4_colour_hold: assert property (@(posedge clk) disable iff (rst)
    !gap_evt |=> $stable({grn_o, red_o, blu_o}));

  // R5: a boundary is only declared while the wire is low
  a_r5_gap_on_low: assert property (@(posedge clk) disable iff (rst)
    gap_evt |-> (!lvl && $past(!lvl)));

  // R7: a forwarded pulse never outlasts the one-width
  a_r7_width_max: assert property (@(posedge clk) disable iff (rst)
    dout |-> (run < 32'(ONE_HI)));

  // R7: every forwarded pulse ends at one of the two legal widths
  a_r7_width_legal: assert property (@(posedge clk) disable iff (rst)
    $fell(dout) |-> (run == 32'(ONE_HI) || run == 32'(ZERO_HI)));

  // R8: pulses start only once this pixel's own bits are complete
  a_r8_fwd_after_full: assert property (@(posedge clk) disable iff (rst)
    $rose(dout) |-> $past(frame_full, 2));
endmodule

bind led_pixel_rx pixrx_chk #(.CHAN_W(CHAN_W), .ONE_HI(ONE_HI), .ZERO_HI(ZERO_HI)) u_chk (
  .clk(clk), .rst(rst), .lvl(lvl), .gap_evt(gap_evt), .frame_full(frame_full),
  .dout(dout), .grn_o(grn_o), .red_o(red_o), .blu_o(blu_o)
);

// File: tb/test_led_pixel_rx.sv
`timescale 1ns/1ps
module test_led_pixel_rx;
  localparam int THR  = 75;
  localparam int GAP  = 6250;
  localparam int ONE  = 100;
  localparam int ZERO = 50;
  localparam int PER  = 156;
  localparam int NVEC = 4;

  // {own colour g,r,b [75:52], forwarded bits [51:28], one width [27:20],
  //  zero width [19:12], long low every 8th bit [11:0] (0 = none)}
  localparam logic [75:0] VEC [NVEC] = '{
    {24'h12A5F0, 24'hC35A81, 8'd100, 8'd50, 12'd0},
    {24'hFF0001, 24'h00FF7E, 8'd75,  8'd74, 12'd0},
    {24'h807F3C, 24'hA500FF, 8'd120, 8'd20, 12'd2500},
    {24'h5AC30F, 24'hFFFFFF, 8'd90,  8'd30, 12'd0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       din = 1'b0;
  logic [7:0] grn_o, red_o, blu_o;
  logic       dout;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int np     = 0;
  int run    = 0;
  int widths [64];

  always #4 clk = ~clk;

  led_pixel_rx i_led_pixel_rx (
    .clk(clk), .rst(rst), .din(din),
    .grn_o(grn_o), .red_o(red_o), .blu_o(blu_o), .dout(dout)
  );

  always @(negedge clk) begin
    if (dout) run++;
    else if (run != 0) begin
      if (np < 64) widths[np] = run;
      np++;
      run = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input bit b, input int ow, input int zw, input int low);
    din = 1'b1;
    repeat (b ? ow : zw) @(negedge clk);
    din = 1'b0;
    repeat (low) @(negedge clk);
  endtask

  task automatic wait_boundary();
    repeat (GAP + ONE + 20) @(negedge clk);
  endtask

  function automatic logic [23:0] colour();
    return {grn_o, red_o, blu_o};
  endfunction

  initial begin
    logic [23:0] prev;
    prev = 24'h0;
    repeat (5) @(negedge clk);
    check(colour() == 24'h0 && dout == 1'b0, "R1 colours and dout at reset",
          {colour(), 7'b0, dout}, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] own, fw;
      int ow, zw, lx, bad, badw;
      own = VEC[i][75:52]; fw = VEC[i][51:28];
      ow = int'(VEC[i][27:20]); zw = int'(VEC[i][19:12]); lx = int'(VEC[i][11:0]);
      np = 0;
      for (int k = 0; k < 48; k++) begin
        bit b;
        int low;
        b   = (k < 24) ? own[23-k] : fw[47-k];
        low = PER - (b ? ow : zw);
        if (lx != 0 && (k % 8) == 7) low = lx;
        send_bit(b, ow, zw, low);
        if (k == 23) check(np == 0, "R8 no pulse during own bits", np, 0);
      end
      check(colour() == prev, "R4 colours hold mid-frame", colour(), prev);
      wait_boundary();
      check(colour() == own, "R3 colour order green red blue", colour(), own);
      if (i == 1) check(grn_o == 8'hFF && blu_o == 8'h01, "R2 threshold 75 vs 74",
                        colour(), own);
      if (i == 2) check(colour() == own, "R5 20us lows not a boundary", colour(), own);
      if (i > 0)  check(colour() == own, "R9 count restarted per frame", colour(), own);
      check(np == 24, "R7 forwarded pulse count", np, 24);
      bad = -1; badw = 0;
      for (int k = 0; k < 24 && k < np; k++) begin
        int ew;
        ew = fw[23-k] ? ONE : ZERO;
        if (widths[k] != ew && bad < 0) begin bad = k; badw = widths[k]; end
      end
      check(bad < 0, "R7 forwarded widths", badw, bad < 0 ? 0 : (fw[23-bad] ? ONE : ZERO));
      prev = own;
    end

    // R6: a short frame is dropped at the boundary
    np = 0;
    for (int k = 0; k < 10; k++) send_bit(k[0], 100, 50, PER - (k[0] ? 100 : 50));
    wait_boundary();
    check(colour() == prev, "R6 short frame ignored", colour(), prev);
    check(np == 0, "R8 idle dout low after short frame", np, 0);

    // R5: a low just below the boundary count keeps the frame together
    begin
      logic [23:0] pat;
      pat = 24'h3C96E1;
      np = 0;
      for (int k = 0; k < 24; k++)
        send_bit(pat[23-k], 100, 50, (k == 11) ? GAP - 10 : PER - (pat[23-k] ? 100 : 50));
      check(colour() == prev, "R5 no boundary at GAP-10", colour(), prev);
      wait_boundary();
      check(colour() == pat, "R5 frame across near-boundary low", colour(), pat);
      prev = pat;
    end

    // R1: reset in mid-run clears everything
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(colour() == 24'h0 && dout == 1'b0, "R1 reset after traffic", colour(), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule